// File: doc/BRIEF.md
# Two-Way Branch Target Buffer with Hashed Tags

This block predicts where a fetched branch goes. The fetch stage gives it a program counter. One cycle later the block says whether it knows that address and, if so, which target to fetch next. The pipeline reports resolved branches on a separate update port. A branch that was taken is written with its target. A branch that was reported not taken has its entry dropped. The drop happens in the same cycle as the report, with no extra cycle to read the entry first.

Storage is split into two ways of `ENTRIES/2` sets each. The tags and targets sit in synchronous RAMs with one read port, and lookups use that port. A flop copy of the tags and a flop valid array serve the update side. Each stored tag is a 16-bit XOR fold of the address bits above the set index, not the full upper address. Two distinct addresses can therefore share an entry.

Top module: `btb_two_way`

## Requirements
- R1: After reset every way is empty, so every lookup misses until a taken update has been written.
- R2: A lookup presented in cycle n is answered in cycle n+1. `rsp_valid` is high in exactly the cycles that follow an accepted lookup, and several lookups can be answered back to back.
- R3: After a taken update for an address, a later lookup of that address hits and returns the written target.
- R4: A taken update whose address already hits in its set overwrites that way's target in place. The entry in the other way of the set is kept.
- R5: A taken update that misses writes the set's least-recently-written way, which is way 0 after reset. The way written becomes most recent. A third distinct tag in a full set evicts the older of the two entries.
- R6: A not-taken update clears the valid bit of the way whose tag matches, and later lookups of that address miss. The other way keeps its entry. A not-taken update that matches nothing changes nothing.
- R7: The stored tag is the XOR of the address bits above the set index, cut into 16-bit chunks starting at the lowest of those bits, with the top chunk zero-padded. Two addresses in the same set with equal folds hit the same entry.
- R8: The set index is the `log2(ENTRIES/2)` address bits just above the lowest `ALIGN_BITS` bits. The alignment bits take no part in the lookup, and entries in different sets do not affect one another.
- R9: When a lookup and an update arrive in the same cycle, both take effect, and the lookup returns the contents as they were before that update.
- R10: When a response is a miss, `rsp_target` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_pc | input | PC_W | Fetch address to look up |
| up_valid | input | 1 | Update strobe from branch resolution |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | 1: write target, 0: remove entry |
| up_target | input | PC_W | Resolved target for a taken branch |
| rsp_valid | output | 1 | Response strobe, one cycle after lookup |
| rsp_hit | output | 1 | Lookup found a valid matching entry |
| rsp_target | output | PC_W | Predicted target, zero on a miss |

## Verification
The bench builds the block with `ENTRIES=16`, `PC_W=32`, `ALIGN_BITS=1` and `TAG_W=16`. That gives eight sets, so a few hand-picked addresses collide in one set, fill both ways and force an eviction. With only 28 bits above the index, a 16-bit fold is easy to alias on purpose, which exercises the hashed tag. The small depth also makes the least-recently-written order visible after three or four updates.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned BTB_WAYS = 2;

  typedef enum logic {
    WAY_0 = 1'b0,
    WAY_1 = 1'b1
  } btb_way_e;
endpackage

// File: rtl/btb_hash.sv
// Splits an address into set index and folded tag.
module btb_hash #(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned ALIGN_BITS = 1,
  parameter int unsigned IDX_W      = 9,
  parameter int unsigned TAG_W      = 16
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  localparam int unsigned LO_BIT  = ALIGN_BITS + IDX_W;
  localparam int unsigned UP_W    = PC_W - LO_BIT;
  localparam int unsigned N_CHUNK = (UP_W + TAG_W - 1) / TAG_W;
  localparam int unsigned PAD_W   = N_CHUNK * TAG_W;

  logic [PAD_W-1:0] upper_pad;

  assign idx       = pc[LO_BIT-1:ALIGN_BITS];
  assign upper_pad = PAD_W'(pc[PC_W-1:LO_BIT]);

  always_comb begin
    tag = '0;
    for (int i = 0; i < int'(N_CHUNK); i++) begin
      tag = tag ^ upper_pad[i*TAG_W +: TAG_W];
    end
  end

  generate
    if (ALIGN_BITS > 0) begin : g_align
      logic unused_align;
      assign unused_align = ^pc[ALIGN_BITS-1:0];
    end
  endgenerate
endmodule

// File: rtl/btb_way.sv
// One way: tag and target RAMs with a single synchronous read port for
// lookups, plus flop valid bits and a flop tag copy for the update side.
module btb_way #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld_q,
  output logic [TAG_W-1:0] rd_tag_q,
  output logic [PC_W-1:0]  rd_tgt_q,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_vld,
  output logic [TAG_W-1:0] chk_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_ram    [SETS];
  logic [PC_W-1:0]  tgt_ram    [SETS];
  logic [TAG_W-1:0] tag_shadow [SETS];
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  vld_d;

  // valid bits: next state
  always_comb begin
    vld_d = vld_q;
    if (clr_en) vld_d[clr_idx] = 1'b0;
    if (wr_en)  vld_d[wr_idx]  = 1'b1;
  end

  // valid bits: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // RAM write port and tag copy
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_ram[wr_idx]    <= wr_tag;
      tgt_ram[wr_idx]    <= wr_tgt;
      tag_shadow[wr_idx] <= wr_tag;
    end
  end

  // single synchronous read port
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag_q <= tag_ram[rd_idx];
      rd_tgt_q <= tgt_ram[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_vld_q <= 1'b0;
    else if (rd_en) rd_vld_q <= vld_q[rd_idx];
  end

  assign chk_vld = vld_q[chk_idx];
  assign chk_tag = tag_shadow[chk_idx];
endmodule

// File: rtl/btb_lru.sv
// One replacement bit per set naming the way to fill next.
module btb_lru
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output btb_way_e         rd_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  btb_way_e         wr_way
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (wr_en) lru_d[wr_idx] = logic'(wr_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign rd_way = btb_way_e'(lru_q[rd_idx]);
endmodule

// File: rtl/btb_two_way.sv
module btb_two_way
  import btb_pkg::*;
#(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned ENTRIES    = 1024,
  parameter int unsigned ALIGN_BITS = 1,
  parameter int unsigned TAG_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [PC_W-1:0] rsp_target
);
  localparam int unsigned SETS  = ENTRIES / BTB_WAYS;
  localparam int unsigned IDX_W = $clog2(SETS);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag, lk_tag_q;
  logic             rsp_vld_q;

  logic [BTB_WAYS-1:0] rd_vld, chk_vld, wr_en_w, clr_en_w, up_match, lk_match;
  logic [TAG_W-1:0]    rd_tag  [BTB_WAYS];
  logic [TAG_W-1:0]    chk_tag [BTB_WAYS];
  logic [PC_W-1:0]     rd_tgt  [BTB_WAYS];

  btb_way_e lru_way, hit_way, victim, lru_new;
  logic     up_hit, lru_wr_en;

  btb_hash #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_hash_lk (.pc(lk_pc), .idx(lk_idx), .tag(lk_tag));

  btb_hash #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_hash_up (.pc(up_pc), .idx(up_idx), .tag(up_tag));

  generate
    for (genvar w = 0; w < BTB_WAYS; w++) begin : g_way
      btb_way #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (lk_valid),
        .rd_idx   (lk_idx),
        .rd_vld_q (rd_vld[w]),
        .rd_tag_q (rd_tag[w]),
        .rd_tgt_q (rd_tgt[w]),
        .chk_idx  (up_idx),
        .chk_vld  (chk_vld[w]),
        .chk_tag  (chk_tag[w]),
        .wr_en    (wr_en_w[w]),
        .wr_idx   (up_idx),
        .wr_tag   (up_tag),
        .wr_tgt   (up_target),
        .clr_en   (clr_en_w[w]),
        .clr_idx  (up_idx)
      );
      assign up_match[w] = chk_vld[w] && (chk_tag[w] == up_tag);
      assign lk_match[w] = rd_vld[w]  && (rd_tag[w]  == lk_tag_q);
    end
  endgenerate

  btb_lru #(.IDX_W(IDX_W)) u_lru (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (up_idx),
    .rd_way (lru_way),
    .wr_en  (lru_wr_en),
    .wr_idx (up_idx),
    .wr_way (lru_new)
  );

  // update decision: way 0 wins when both match
  always_comb begin
    hit_way   = up_match[0] ? WAY_0 : WAY_1;
    up_hit    = |up_match;
    victim    = up_hit ? hit_way : lru_way;
    wr_en_w   = '0;
    clr_en_w  = '0;
    lru_wr_en = 1'b0;
    lru_new   = WAY_0;
    if (up_valid) begin
      if (up_taken) begin
        wr_en_w[victim] = 1'b1;
        lru_wr_en       = 1'b1;
        lru_new         = btb_way_e'(~victim);
      end else if (up_hit) begin
        clr_en_w[hit_way] = 1'b1;
      end
    end
  end

  // lookup pipeline register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_vld_q <= 1'b0;
    else        rsp_vld_q <= lk_valid;
  end

  always_ff @(posedge clk) begin
    if (lk_valid) lk_tag_q <= lk_tag;
  end

  // response select
  always_comb begin
    rsp_valid  = rsp_vld_q;
    rsp_hit    = rsp_vld_q && (|lk_match);
    rsp_target = '0;
    if (rsp_vld_q) begin
      if (lk_match[0])      rsp_target = rd_tgt[0];
      else if (lk_match[1]) rsp_target = rd_tgt[1];
    end
  end
endmodule

// File: rtl/btb_two_way_chk.sv
module btb_two_way_chk #(
  parameter int unsigned PC_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [PC_W-1:0] lk_pc,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic [PC_W-1:0] up_target,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PC_W-1:0] rsp_target
);
  logic            seen_taken, ins_v, rem_v;
  logic [PC_W-1:0] ins_pc, ins_tgt, rem_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_taken <= 1'b0;
      ins_v      <= 1'b0;
      rem_v      <= 1'b0;
      ins_pc     <= '0;
      ins_tgt    <= '0;
      rem_pc     <= '0;
    end else begin
      if (up_valid && up_taken) seen_taken <= 1'b1;
      ins_v   <= up_valid && up_taken;
      rem_v   <= up_valid && !up_taken;
      ins_pc  <= up_pc;
      ins_tgt <= up_target;
      rem_pc  <= up_pc;
    end
  end

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> seen_taken);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  p_install_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && ins_v && lk_pc == ins_pc) |=> (rsp_hit && rsp_target == $past(ins_tgt)));

  p_removed_misses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && rem_v && lk_pc == rem_pc) |=> !rsp_hit);

  p_miss_zero_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_target == '0));
endmodule

bind btb_two_way btb_two_way_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_pc      (lk_pc),
  .up_valid   (up_valid),
  .up_pc      (up_pc),
  .up_taken   (up_taken),
  .up_target  (up_target),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_target (rsp_target)
);

// File: tb/btb_two_way_test.sv
`timescale 1ns/1ps
module btb_two_way_test;
  localparam int unsigned PC_W = 32;

  logic            clk;
  logic            rst_n;
  logic            lk_valid;
  logic [PC_W-1:0] lk_pc;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_taken;
  logic [PC_W-1:0] up_target;
  logic            rsp_valid;
  logic            rsp_hit;
  logic [PC_W-1:0] rsp_target;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 0;

  logic            exp_hit_q [$];
  logic [PC_W-1:0] exp_tgt_q [$];
  string           exp_rq_q  [$];

  btb_two_way #(.PC_W(PC_W), .ENTRIES(16), .ALIGN_BITS(1), .TAG_W(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // address = upper bits above index, set index, alignment bit zero
  function automatic logic [PC_W-1:0] mkpc(input int unsigned upper, input int unsigned set);
    return PC_W'((upper << 4) | (set << 1));
  endfunction

  task automatic report(input bit ok, input string rq, input string what,
                        input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected response queued for the monitor
  task automatic step(input logic lkv, input logic [PC_W-1:0] lkpc,
                      input logic upv, input logic [PC_W-1:0] uppc,
                      input logic tk, input logic [PC_W-1:0] tgt,
                      input logic eh, input logic [PC_W-1:0] et, input string rq);
    @(negedge clk);
    lk_valid  = lkv;
    lk_pc     = lkpc;
    up_valid  = upv;
    up_pc     = uppc;
    up_taken  = tk;
    up_target = tgt;
    if (lkv) begin
      exp_hit_q.push_back(eh);
      exp_tgt_q.push_back(et);
      exp_rq_q.push_back(rq);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input logic eh,
                      input logic [PC_W-1:0] et, input string rq);
    step(1'b1, pc, 1'b0, '0, 1'b0, '0, eh, et, rq);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt);
    step(1'b0, '0, 1'b1, pc, tk, tgt, 1'b0, '0, "");
  endtask

  // monitor: compare each response against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      if (exp_hit_q.size() == 0) begin
        report(1'b0, "R2", "unexpected response", {31'b0, rsp_valid}, '0);
      end else begin
        logic            eh;
        logic [PC_W-1:0] et;
        string           rq;
        eh = exp_hit_q.pop_front();
        et = exp_tgt_q.pop_front();
        rq = exp_rq_q.pop_front();
        report(rsp_hit == eh, rq, "hit", {31'b0, rsp_hit}, {31'b0, eh});
        report(rsp_target == et, rq, "target", rsp_target, et);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [PC_W-1:0] T1 = 32'h0000_0100;
  localparam logic [PC_W-1:0] T2 = 32'h0000_0200;
  localparam logic [PC_W-1:0] T3 = 32'h0000_0300;
  localparam logic [PC_W-1:0] T4 = 32'h0000_0210;
  localparam logic [PC_W-1:0] T5 = 32'h0000_0400;

  initial begin
    logic [PC_W-1:0] pa, pb, pc_c, pd, palias, pe;
    pa     = mkpc(1, 1);
    pb     = mkpc(2, 1);
    pc_c   = mkpc(3, 1);
    pd     = mkpc(5, 1);
    palias = mkpc(32'h10000, 1);   // fold: 0x0000 ^ 0x0001 = tag of pa
    pe     = mkpc(1, 2);

    rst_n = 1'b0; lk_valid = 0; lk_pc = '0; up_valid = 0; up_pc = '0; up_taken = 0; up_target = '0;
    repeat (3) @(negedge clk);
    report(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'b0, rsp_valid}, '0);
    rst_n = 1'b1;

    look(pa, 1'b0, '0, "R1");                       // empty after reset, zero target (R10)
    upd(pa, 1'b1, T1);                               // way 0 takes pa
    look(pa, 1'b1, T1, "R3");
    step(1'b1, pa, 1'b1, pa, 1'b1, T2, 1'b1, T1, "R9"); // lookup sees old target
    look(pa, 1'b1, T2, "R4");
    upd(pb, 1'b1, T3);                               // miss, fills way 1
    look(pb, 1'b1, T3, "R5");
    look(pa, 1'b1, T2, "R5");
    upd(pa, 1'b1, T4);                               // in place, way 1 becomes victim
    look(pa, 1'b1, T4, "R4");
    look(pb, 1'b1, T3, "R4");
    upd(pc_c, 1'b1, T5);                             // evicts pb
    look(pb, 1'b0, '0, "R5");
    look(pc_c, 1'b1, T5, "R5");
    look(pa, 1'b1, T4, "R5");
    upd(pc_c, 1'b0, '0);                             // remove pc_c
    look(pc_c, 1'b0, '0, "R6");
    look(pa, 1'b1, T4, "R6");
    upd(pd, 1'b0, '0);                               // no matching entry
    look(pa, 1'b1, T4, "R6");
    look(palias, 1'b1, T4, "R7");
    look(pe, 1'b0, '0, "R8");
    look(pa | 32'h1, 1'b1, T4, "R8");

    // R2: idle cycle produces no response
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "");
    @(posedge clk); #1;
    @(posedge clk); #1;
    report(rsp_valid == 1'b0, "R2", "rsp_valid after idle", {31'b0, rsp_valid}, '0);
    repeat (2) @(negedge clk);
    report(exp_hit_q.size() == 0, "R2", "unanswered lookups",
           PC_W'(exp_hit_q.size()), '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule